// File: doc/BRIEF.md
# Packed Lane Shuffle Unpack Unit

This unit rearranges the 32-bit lanes of two 128-bit operands into one 128-bit result. Each operand is four lanes, lane 0 in bits [31:0] up to lane 3 in bits [127:96]. In shuffle mode the two low result lanes are each taken from any lane of operand A, and the two high result lanes are each taken from any lane of operand B. An 8-bit control gives two select bits per result lane. Passing the same value on both operands turns the shuffle into a free permutation of four lanes.

In unpack-high mode the upper lanes of the two operands are interleaved in a fixed order and the control is not used. Lane data is copied bit for bit, so any 32-bit pattern passes through unchanged, including floating-point NaN payloads. The result is registered. A new operation can be issued every cycle, and the result appears one cycle after its strobe.

Top module: `lane_permute_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first operation, out_valid is 0 and out_data is all zeros.
- R2: out_valid is 1 in the cycle after a cycle with in_valid high and 0 otherwise. Back-to-back strobes give back-to-back results.
- R3: In shuffle mode (in_mode = 0), result lane i for i = 0 and 1 equals the lane of in_opa numbered by in_ctrl[2i+1:2i].
- R4: In shuffle mode, result lane i for i = 2 and 3 equals the lane of in_opb numbered by in_ctrl[2i+1:2i].
- R5: In unpack-high mode (in_mode = 1), result lanes 0, 1, 2 and 3 are in_opa lane 2, in_opb lane 2, in_opa lane 3 and in_opb lane 3.
- R6: In unpack-high mode, the value of in_ctrl has no effect on the result.
- R7: In a cycle with in_valid low, out_data keeps its previous value whatever the other inputs do.
- R8: Lane contents are copied bit-exact, so NaN and other special 32-bit patterns are preserved.
- R9: With the same value on in_opa and in_opb, a shuffle can place the four lanes in any order, for example full reversal with in_ctrl = 8'h1B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operation strobe |
| in_mode | input | 1 | 0 = shuffle, 1 = unpack-high |
| in_ctrl | input | 8 | Shuffle lane selects, 2 bits per result lane |
| in_opa | input | 128 | Operand A, four 32-bit lanes |
| in_opb | input | 128 | Operand B, four 32-bit lanes |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_data | output | 128 | Registered result |

## Verification
Two things can happen in the same cycle. A finished result is shown on the outputs while the next operation, often in the other mode, is captured. The bench drives its vector table with no gaps and switches between shuffle and unpack-high on neighbouring vectors. Each result is checked in full in the cycle after its strobe, so a stale lane or a mode used on the wrong operation shows up as a mismatch.

// File: rtl/lane_perm_pkg.sv
`timescale 1ns/1ps
package lane_perm_pkg;
  localparam int unsigned LANE_W_DEF  = 32;
  localparam int unsigned N_LANES_DEF = 4;

  typedef enum logic {
    PERM_SHUFFLE   = 1'b0,
    PERM_UNPACK_HI = 1'b1
  } perm_mode_e;
endpackage

// File: rtl/lpu_reset_sync.sv
`timescale 1ns/1ps
module lpu_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/lpu_shuffle_path.sv
`timescale 1ns/1ps
module lpu_shuffle_path #(
  parameter int unsigned LANE_W  = 32,
  parameter int unsigned N_LANES = 4,
  localparam int unsigned SEL_W  = $clog2(N_LANES),
  localparam int unsigned CTRL_W = N_LANES * SEL_W,
  localparam int unsigned DW     = N_LANES * LANE_W
) (
  input  logic [DW-1:0]     opa,
  input  logic [DW-1:0]     opb,
  input  logic [CTRL_W-1:0] ctrl,
  output logic [DW-1:0]     res
);
  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    logic [SEL_W-1:0]  sel;
    logic [DW-1:0]     src;
    logic [LANE_W-1:0] lane_val;

    assign sel = ctrl[i*SEL_W +: SEL_W];

    if (i < N_LANES/2) begin : g_from_a
      assign src = opa;
    end else begin : g_from_b
      assign src = opb;
    end

    always_comb begin
      lane_val = '0;
      for (int k = 0; k < N_LANES; k++) begin
        if (sel == k[SEL_W-1:0]) lane_val = src[k*LANE_W +: LANE_W];
      end
    end

    assign res[i*LANE_W +: LANE_W] = lane_val;
  end
endmodule

// File: rtl/lpu_unpack_path.sv
`timescale 1ns/1ps
module lpu_unpack_path #(
  parameter int unsigned LANE_W  = 32,
  parameter int unsigned N_LANES = 4,
  localparam int unsigned HALF   = N_LANES / 2,
  localparam int unsigned HW     = HALF * LANE_W,
  localparam int unsigned DW     = N_LANES * LANE_W
) (
  input  logic [HW-1:0] opa_hi,
  input  logic [HW-1:0] opb_hi,
  output logic [DW-1:0] res
);
  for (genvar j = 0; j < HALF; j++) begin : g_pair
    assign res[(2*j)*LANE_W   +: LANE_W] = opa_hi[j*LANE_W +: LANE_W];
    assign res[(2*j+1)*LANE_W +: LANE_W] = opb_hi[j*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/lpu_result_reg.sv
`timescale 1ns/1ps
module lpu_result_reg #(
  parameter int unsigned DW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] data_in,
  output logic          valid_q,
  output logic [DW-1:0] data_q
);
  logic [DW-1:0] data_d;

  always_comb begin
    data_d = data_q;
    if (load) data_d = data_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= load;
      data_q  <= data_d;
    end
  end
endmodule

// File: rtl/lane_permute_unit.sv
`timescale 1ns/1ps
module lane_permute_unit #(
  parameter int unsigned LANE_W  = lane_perm_pkg::LANE_W_DEF,
  parameter int unsigned N_LANES = lane_perm_pkg::N_LANES_DEF,
  localparam int unsigned SEL_W  = $clog2(N_LANES),
  localparam int unsigned CTRL_W = N_LANES * SEL_W,
  localparam int unsigned DW     = N_LANES * LANE_W,
  localparam int unsigned HW     = (N_LANES / 2) * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_mode,
  input  logic [CTRL_W-1:0] in_ctrl,
  input  logic [DW-1:0]     in_opa,
  input  logic [DW-1:0]     in_opb,
  output logic              out_valid,
  output logic [DW-1:0]     out_data
);
  import lane_perm_pkg::*;

  logic       rst_n_sync;
  perm_mode_e mode;
  logic [DW-1:0] shuf_res;
  logic [DW-1:0] unpk_res;
  logic [DW-1:0] next_res;

  lpu_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  lpu_shuffle_path #(.LANE_W(LANE_W), .N_LANES(N_LANES)) u_shuf (
    .opa  (in_opa),
    .opb  (in_opb),
    .ctrl (in_ctrl),
    .res  (shuf_res)
  );

  lpu_unpack_path #(.LANE_W(LANE_W), .N_LANES(N_LANES)) u_unpk (
    .opa_hi (in_opa[DW-1 -: HW]),
    .opb_hi (in_opb[DW-1 -: HW]),
    .res    (unpk_res)
  );

  always_comb begin
    mode = perm_mode_e'(in_mode);
    unique case (mode)
      PERM_UNPACK_HI: next_res = unpk_res;
      default:        next_res = shuf_res;
    endcase
  end

  lpu_result_reg #(.DW(DW)) u_out (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .load    (in_valid),
    .data_in (next_res),
    .valid_q (out_valid),
    .data_q  (out_data)
  );
endmodule

// File: rtl/lane_permute_unit_chk.sv
`timescale 1ns/1ps
module lane_permute_unit_chk #(
  parameter int unsigned LANE_W  = 32,
  parameter int unsigned N_LANES = 4,
  localparam int unsigned SEL_W  = $clog2(N_LANES),
  localparam int unsigned CTRL_W = N_LANES * SEL_W,
  localparam int unsigned DW     = N_LANES * LANE_W,
  localparam int unsigned HALF   = N_LANES / 2
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              in_valid,
  input logic              in_mode,
  input logic [CTRL_W-1:0] in_ctrl,
  input logic [DW-1:0]     in_opa,
  input logic [DW-1:0]     in_opb,
  input logic              out_valid,
  input logic [DW-1:0]     out_data
);
  function automatic logic [LANE_W-1:0] pick(input logic [DW-1:0] v, input int idx);
    return v[idx*LANE_W +: LANE_W];
  endfunction

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid |=> out_valid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> !out_valid);
  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> $stable(out_data));

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    if (i < HALF) begin : g_lo
      // R3
      shuf_lo_chk: assert property (@(posedge clk) disable iff (!rst_ok)
        (in_valid && !in_mode) |=>
          out_data[i*LANE_W +: LANE_W] ==
          pick($past(in_opa), int'($past(in_ctrl[i*SEL_W +: SEL_W]))));
    end else begin : g_hi
      // R4
      shuf_hi_chk: assert property (@(posedge clk) disable iff (!rst_ok)
        (in_valid && !in_mode) |=>
          out_data[i*LANE_W +: LANE_W] ==
          pick($past(in_opb), int'($past(in_ctrl[i*SEL_W +: SEL_W]))));
    end
    if (i % 2 == 0) begin : g_even
      // R5
      unpk_a_chk: assert property (@(posedge clk) disable iff (!rst_ok)
        (in_valid && in_mode) |=>
          out_data[i*LANE_W +: LANE_W] == pick($past(in_opa), HALF + i/2));
    end else begin : g_odd
      // R5
      unpk_b_chk: assert property (@(posedge clk) disable iff (!rst_ok)
        (in_valid && in_mode) |=>
          out_data[i*LANE_W +: LANE_W] == pick($past(in_opb), HALF + i/2));
    end
  end
endmodule

bind lane_permute_unit lane_permute_unit_chk #(.LANE_W(LANE_W), .N_LANES(N_LANES)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_n_sync),
  .in_valid  (in_valid),
  .in_mode   (in_mode),
  .in_ctrl   (in_ctrl),
  .in_opa    (in_opa),
  .in_opb    (in_opb),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/tb_lane_permute_unit.sv
`timescale 1ns/1ps
module tb_lane_permute_unit;
  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic         in_mode;
  logic [7:0]   in_ctrl;
  logic [127:0] in_opa;
  logic [127:0] in_opb;
  logic         out_valid;
  logic [127:0] out_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  lane_permute_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_ctrl(in_ctrl), .in_opa(in_opa), .in_opb(in_opb),
    .out_valid(out_valid), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Operand A lanes carry NaN and odd patterns for R8
  localparam logic [31:0] A0 = 32'h1111_0000;
  localparam logic [31:0] A1 = 32'hFF80_0001;
  localparam logic [31:0] A2 = 32'h7FA0_0002;
  localparam logic [31:0] A3 = 32'h7FC0_1233;
  localparam logic [31:0] B0 = 32'hBBBB_0000;
  localparam logic [31:0] B1 = 32'hBBBB_0001;
  localparam logic [31:0] B2 = 32'hBBBB_0002;
  localparam logic [31:0] B3 = 32'hBBBB_0003;
  localparam logic [127:0] OPA = {A3, A2, A1, A0};
  localparam logic [127:0] OPB = {B3, B2, B1, B0};

  // {mode, ctrl, expected lanes 3..0}
  localparam int NV = 9;
  localparam logic [136:0] VT [NV] = '{
    {1'b0, 8'hE4, B3, B2, A1, A0},
    {1'b0, 8'h1B, B0, B1, A2, A3},
    {1'b1, 8'h00, B3, A3, B2, A2},
    {1'b0, 8'h00, B0, B0, A0, A0},
    {1'b1, 8'hE4, B3, A3, B2, A2},
    {1'b0, 8'hFF, B3, B3, A3, A3},
    {1'b0, 8'h72, B1, B3, A0, A2},
    {1'b1, 8'h5A, B3, A3, B2, A2},
    {1'b0, 8'h9C, B2, B1, A3, A0}
  };

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_mode = 1'b0; in_ctrl = '0;
    in_opa = '0; in_opb = '0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", {127'b0, out_valid}, 128'b0);
    check("R1 reset data", out_data, 128'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 post-release data", out_data, 128'b0);

    // table walk, back-to-back, modes mixed (R2 R3 R4 R5 R6 R8)
    in_opa = OPA; in_opb = OPB;
    for (int k = 0; k <= NV; k++) begin
      if (k > 0) begin
        check("R2 valid", {127'b0, out_valid}, 128'b1);
        check(VT[k-1][136] ? "R5/R6 unpack" : "R3/R4/R8 shuffle", out_data, VT[k-1][127:0]);
      end
      if (k < NV) begin
        in_valid = 1'b1; in_mode = VT[k][136]; in_ctrl = VT[k][135:128];
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
    end

    // R7: idle cycles with changing inputs keep the result
    in_mode = 1'b1; in_ctrl = 8'h33; in_opa = ~OPA; in_opb = ~OPB;
    @(negedge clk);
    check("R7 hold data", out_data, {B2, B1, A3, A0});
    check("R2 idle valid", {127'b0, out_valid}, 128'b0);
    in_mode = 1'b0;
    @(negedge clk);
    check("R7 hold data 2", out_data, {B2, B1, A3, A0});

    // R9: same operand on both sides, full reversal
    in_valid = 1'b1; in_mode = 1'b0; in_ctrl = 8'h1B;
    in_opa = OPA; in_opb = OPA;
    @(negedge clk);
    check("R9 reverse", out_data, {A0, A1, A2, A3});
    // R9: rotate by one with 8'h93 (sel 2,1,0,3)
    in_ctrl = 8'h93;
    @(negedge clk);
    check("R9 rotate", out_data, {A2, A1, A0, A3});

    // R6: unpack with two different controls gives same result
    in_mode = 1'b1; in_ctrl = 8'hFF; in_opb = OPB;
    @(negedge clk);
    check("R6 unpack ctrl FF", out_data, {B3, A3, B2, A2});
    in_ctrl = 8'h00;
    @(negedge clk);
    check("R6 unpack ctrl 00", out_data, {B3, A3, B2, A2});

    // R1: reset in the middle of traffic clears at once
    #1 rst_n = 1'b0;
    #1;
    check("R1 mid reset valid", {127'b0, out_valid}, 128'b0);
    check("R1 mid reset data", out_data, 128'b0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after mid reset", out_data, 128'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule